// File: doc/BRIEF.md
# Class-Latency Register Scoreboard

This block keeps, for each architectural destination register, a count of the cycles left until a pending result can be read. A producer that issues loads a latency. That latency comes from the operation class of the producer. On every cycle the block checks the one incoming request. The request names two source registers and the class of the consuming operation, and the block reports at once whether each source can be read.

If any named source is still pending, the request is stalled and nothing is recorded. Otherwise the destination register is loaded with its new latency, and the producer's class is kept so that a later consumer can look it up.

Wide (128-bit) vector move, add and multiply results reach the upper half of the register only in their last cycle. A wide consumer reads that upper half one cycle late. So when both producer and consumer belong to the wide move/add/multiply group, the consumer may issue one cycle earlier than the full latency. The top register index is a hard-wired zero: it never blocks a request and is never recorded.

Top module: `lat_scoreboard`

## Requirements
- R1: After reset every register reads as ready. A valid request therefore shows both source-ready outputs high and `stall` low.
- R2: Class codes 0 (simple ALU/shift), 1 (arithmetic with shift or extend, conditional select), 2 (integer load) and 3 (multiply, CRC) give latencies 1, 2, 3 and 4. Codes 19 to 31 are unassigned and give latency 1. A producer accepted in cycle t with latency L makes its register ready from cycle t+L, and not before.
- R3: Scalar floating-point codes give these latencies: 5 (add) 4, 6 (multiply, multiply-add) 6, 7 (compare, conditional select) 3, 8 (move, min/max) 2.
- R4: Long-latency codes give these latencies: 4 (integer divide) 22, 9 (single divide) 12, 10 (double divide) 22, 11 (single square root) 17, 12 (double square root) 31.
- R5: Vector codes 13, 14 and 15 (64-bit move, add, multiply) give 2, 4 and 6. Codes 16, 17 and 18 (128-bit move, add, multiply) give 3, 5 and 7 for any consumer outside codes 16 to 18.
- R6: When a producer of code 16, 17 or 18 feeds a consumer of code 16, 17 or 18, the effective latency is 2, 4 or 6, set by the producer.
- R7: The shortened latency applies only when both producer and consumer are in codes 16 to 18. A 64-bit vector producer or consumer in the pair gives the full latency.
- R8: Register 31 as a source is always ready. As a destination it is never recorded.
- R9: `stall` is high exactly when `iss_valid` is high and a source-ready output is low. A stalled request leaves every register's pending state unchanged.
- R10: A request with `iss_valid` low, or with `iss_dst_en` low, records nothing.
- R11: An accepted producer replaces any older pending state of its destination, including a longer one. The source-ready outputs reflect the named sources even when `iss_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | A request is presented this cycle |
| iss_src0 | input | 5 | First source register index |
| iss_src1 | input | 5 | Second source register index |
| iss_dst_en | input | 1 | The request writes a destination |
| iss_dst | input | 5 | Destination register index |
| iss_cls | input | 5 | Operation class code of the request |
| src0_rdy | output | 1 | First source readable this cycle |
| src1_rdy | output | 1 | Second source readable this cycle |
| stall | output | 1 | Request held back, nothing recorded |

## Verification
The ready outputs and `stall` depend combinationally on the request and the stored state. They are due in the same cycle the request is presented. An accepted producer affects readiness from the next cycle onward. A consumer of class latency E that arrives E-1 cycles after its producer must see not-ready, and one that arrives E cycles after must see ready. The bench drives each request just after the falling edge and samples the outputs 1 ns later. It advances its behavioural model, which holds an issue cycle and class per register, only at the rising edge that the design uses to record. Directed sweeps poll a consumer every cycle after each producer class, so both sides of every latency boundary are compared. A long random mix then exercises overwrites, stalls and the forwarding pairs.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  localparam int CLS_W   = 5;
  localparam int MAX_LAT = 31;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  typedef enum logic [CLS_W-1:0] {
    C_ALU      = 5'd0,
    C_ALU_EXT  = 5'd1,
    C_LOAD     = 5'd2,
    C_IMUL     = 5'd3,
    C_IDIV     = 5'd4,
    C_FADD     = 5'd5,
    C_FMUL     = 5'd6,
    C_FCMP     = 5'd7,
    C_FMOV     = 5'd8,
    C_FDIV_S   = 5'd9,
    C_FDIV_D   = 5'd10,
    C_FSQRT_S  = 5'd11,
    C_FSQRT_D  = 5'd12,
    C_V64_MOV  = 5'd13,
    C_V64_ADD  = 5'd14,
    C_V64_MUL  = 5'd15,
    C_V128_MOV = 5'd16,
    C_V128_ADD = 5'd17,
    C_V128_MUL = 5'd18
  } op_class_e;

  // full result latency of a producer class
  function automatic logic [CNT_W-1:0] class_lat(input logic [CLS_W-1:0] c);
    case (op_class_e'(c))
      C_ALU:      class_lat = CNT_W'(1);
      C_ALU_EXT:  class_lat = CNT_W'(2);
      C_LOAD:     class_lat = CNT_W'(3);
      C_IMUL:     class_lat = CNT_W'(4);
      C_IDIV:     class_lat = CNT_W'(22);
      C_FADD:     class_lat = CNT_W'(4);
      C_FMUL:     class_lat = CNT_W'(6);
      C_FCMP:     class_lat = CNT_W'(3);
      C_FMOV:     class_lat = CNT_W'(2);
      C_FDIV_S:   class_lat = CNT_W'(12);
      C_FDIV_D:   class_lat = CNT_W'(22);
      C_FSQRT_S:  class_lat = CNT_W'(17);
      C_FSQRT_D:  class_lat = CNT_W'(31);
      C_V64_MOV:  class_lat = CNT_W'(2);
      C_V64_ADD:  class_lat = CNT_W'(4);
      C_V64_MUL:  class_lat = CNT_W'(6);
      C_V128_MOV: class_lat = CNT_W'(3);
      C_V128_ADD: class_lat = CNT_W'(5);
      C_V128_MUL: class_lat = CNT_W'(7);
      default:    class_lat = CNT_W'(1);
    endcase
  endfunction

  // member of the wide vector move/add/multiply group
  function automatic logic is_wide(input logic [CLS_W-1:0] c);
    is_wide = (c == C_V128_MOV) || (c == C_V128_ADD) || (c == C_V128_MUL);
  endfunction

  // latency seen by a wide consumer of a wide producer
  function automatic logic [CNT_W-1:0] wide_fwd_lat(input logic [CLS_W-1:0] c);
    case (op_class_e'(c))
      C_V128_MOV: wide_fwd_lat = CNT_W'(2);
      C_V128_ADD: wide_fwd_lat = CNT_W'(4);
      C_V128_MUL: wide_fwd_lat = CNT_W'(6);
      default:    wide_fwd_lat = class_lat(c);
    endcase
  endfunction
endpackage

// File: rtl/lsb_slot.sv
module lsb_slot #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_cnt,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (ld)         cnt <= ld_cnt;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  // R2
  cnt_decay_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld && cnt != '0) |=> (cnt < $past(cnt)));
endmodule

// File: rtl/lsb_cls_mem.sv
module lsb_cls_mem #(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int DW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr0,
  input  logic [AW-1:0] raddr1,
  output logic [DW-1:0] rdata0,
  output logic [DW-1:0] rdata1
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1];
endmodule

// File: rtl/lsb_src_chk.sv
module lsb_src_chk
  import lsb_pkg::*;
#(
  parameter int RW       = 5,
  parameter int ZERO_REG = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RW-1:0]    src,
  input  logic [CNT_W-1:0] prod_cnt,
  input  logic [CLS_W-1:0] prod_cls,
  input  logic [CLS_W-1:0] cons_cls,
  output logic             rdy
);
  logic             wide_pair;
  logic [CNT_W-1:0] thr;

  always_comb begin
    wide_pair = 1'b0;
    thr       = CNT_W'(1);
    if (prod_cnt > CNT_W'(1)) begin
      wide_pair = is_wide(prod_cls) && is_wide(cons_cls);
      if (wide_pair)
        thr = CNT_W'(1) + class_lat(prod_cls) - wide_fwd_lat(prod_cls);
    end
    rdy = (src == RW'(ZERO_REG)) || (prod_cnt <= thr);
  end

  // R7
  wide_only_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy && src != RW'(ZERO_REG) && prod_cnt > CNT_W'(1))
      |-> (is_wide(prod_cls) && is_wide(cons_cls)));
endmodule

// File: rtl/lat_scoreboard.sv
module lat_scoreboard
  import lsb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int ZERO_REG = NUM_REGS - 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        iss_valid,
  input  logic [$clog2(NUM_REGS)-1:0] iss_src0,
  input  logic [$clog2(NUM_REGS)-1:0] iss_src1,
  input  logic                        iss_dst_en,
  input  logic [$clog2(NUM_REGS)-1:0] iss_dst,
  input  logic [CLS_W-1:0]            iss_cls,
  output logic                        src0_rdy,
  output logic                        src1_rdy,
  output logic                        stall
);
  localparam int RW      = $clog2(NUM_REGS);
  localparam int NUM_SRC = 2;

  logic [CNT_W-1:0] slot_cnt [NUM_REGS];
  logic [RW-1:0]    src_sel  [NUM_SRC];
  logic [CLS_W-1:0] src_cls  [NUM_SRC];
  logic [NUM_SRC-1:0] rdy_vec;
  logic             accept;

  assign src_sel[0] = iss_src0;
  assign src_sel[1] = iss_src1;

  assign stall  = iss_valid && !(&rdy_vec);
  assign accept = iss_valid && iss_dst_en && !stall && (iss_dst != RW'(ZERO_REG));

  genvar r;
  generate
    for (r = 0; r < NUM_REGS; r++) begin : g_slot
      if (r == ZERO_REG) begin : g_zero
        assign slot_cnt[r] = '0;
      end else begin : g_live
        lsb_slot #(.CNT_W(CNT_W)) u_slot (
          .clk    (clk),
          .rst    (rst),
          .ld     (accept && (iss_dst == RW'(r))),
          .ld_cnt (class_lat(iss_cls)),
          .cnt    (slot_cnt[r])
        );
      end
    end
  endgenerate

  lsb_cls_mem #(.DEPTH(NUM_REGS), .AW(RW), .DW(CLS_W)) u_cls (
    .clk    (clk),
    .we     (accept),
    .waddr  (iss_dst),
    .wdata  (iss_cls),
    .raddr0 (src_sel[0]),
    .raddr1 (src_sel[1]),
    .rdata0 (src_cls[0]),
    .rdata1 (src_cls[1])
  );

  genvar s;
  generate
    for (s = 0; s < NUM_SRC; s++) begin : g_src
      lsb_src_chk #(.RW(RW), .ZERO_REG(ZERO_REG)) u_chk (
        .clk      (clk),
        .rst      (rst),
        .src      (src_sel[s]),
        .prod_cnt (slot_cnt[src_sel[s]]),
        .prod_cls (src_cls[s]),
        .cons_cls (iss_cls),
        .rdy      (rdy_vec[s])
      );
    end
  endgenerate

  assign src0_rdy = rdy_vec[0];
  assign src1_rdy = rdy_vec[1];

  // R8
  zero_src_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_src0 == RW'(ZERO_REG)) |-> src0_rdy);

  // R11
  record_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_dst_en && !stall && iss_dst != RW'(ZERO_REG))
      |=> (slot_cnt[$past(iss_dst)] == class_lat($past(iss_cls))));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && stall) |=> (slot_cnt[$past(iss_dst)] <= $past(slot_cnt[iss_dst])));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!iss_valid || !iss_dst_en) |=> (slot_cnt[$past(iss_dst)] <= $past(slot_cnt[iss_dst])));
endmodule

// File: tb/lat_scoreboard_test.sv
module lat_scoreboard_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_valid = 1'b0;
  logic [4:0] iss_src0 = 5'd31, iss_src1 = 5'd31, iss_dst = 5'd31, iss_cls = 5'd0;
  logic iss_dst_en = 1'b0;
  logic src0_rdy, src1_rdy, stall;

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int iss_t [32];
  int pcls  [32];

  always #10 clk = ~clk;

  lat_scoreboard uut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_src0(iss_src0),
    .iss_src1(iss_src1), .iss_dst_en(iss_dst_en), .iss_dst(iss_dst),
    .iss_cls(iss_cls), .src0_rdy(src0_rdy), .src1_rdy(src1_rdy), .stall(stall)
  );

  function automatic int lat_of(int c);
    case (c)
      0: return 1;  1: return 2;  2: return 3;  3: return 4;  4: return 22;
      5: return 4;  6: return 6;  7: return 3;  8: return 2;  9: return 12;
      10: return 22; 11: return 17; 12: return 31; 13: return 2; 14: return 4;
      15: return 6; 16: return 3; 17: return 5; 18: return 7;
      default: return 1;
    endcase
  endfunction

  function automatic bit wide(int c);
    return (c >= 16 && c <= 18);
  endfunction

  function automatic bit exp_rdy(int src, int cons);
    int e;
    if (src == 31) return 1'b1;
    e = lat_of(pcls[src]);
    if (wide(pcls[src]) && wide(cons)) e = e - 1;
    return (cyc >= iss_t[src] + e);
  endfunction

  task automatic chk(bit ok, string tag, string what, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s got %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  task automatic step(bit v, int s0, int s1, bit de, int d, int c, string tag);
    bit e0, e1, es;
    @(negedge clk);
    iss_valid = v; iss_src0 = 5'(s0); iss_src1 = 5'(s1);
    iss_dst_en = de; iss_dst = 5'(d); iss_cls = 5'(c);
    #1;
    e0 = exp_rdy(s0, c);
    e1 = exp_rdy(s1, c);
    es = v && !(e0 && e1);
    chk(src0_rdy == e0, tag, "src0_rdy", src0_rdy, e0);
    chk(src1_rdy == e1, tag, "src1_rdy", src1_rdy, e1);
    chk(stall == es, tag, "stall", stall, es);
    if (v && de && d != 31 && !es) begin
      iss_t[d] = cyc;
      pcls[d]  = c;
    end
    @(posedge clk);
    cyc++;
  endtask

  function automatic string tag_of(int c);
    if (c <= 3) return "R2";
    if (c == 4 || (c >= 9 && c <= 12)) return "R4";
    if (c <= 8) return "R3";
    return "R5";
  endfunction

  // producer to register 5, then a consumer polls it every cycle until accepted
  task automatic lat_probe(int p, int cons, string tag);
    step(1, 31, 31, 1, 5, p, tag);
    for (int k = 0; k < 40; k++) begin
      step(1, 5, 31, 1, 6, cons, tag);
      if (!stall) break;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin iss_t[i] = -1000; pcls[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: every register ready after reset
    for (int i = 0; i < 32; i += 2) step(1, i, i + 1, 0, 0, 0, "R1");

    // R2 R3 R4 R5: full latency of each class, incl. unassigned codes
    for (int c = 0; c < 19; c++) lat_probe(c, 0, tag_of(c));
    lat_probe(25, 0, "R2");
    lat_probe(31, 0, "R2");

    // R6: wide producer feeding wide consumer
    for (int p = 16; p <= 18; p++)
      for (int q = 16; q <= 18; q++) lat_probe(p, q, "R6");

    // R7: only one side wide
    lat_probe(17, 15, "R7");
    lat_probe(15, 17, "R7");
    lat_probe(18, 13, "R7");
    lat_probe(14, 18, "R7");

    // R8: register 31 never recorded, always ready
    step(1, 31, 31, 1, 31, 12, "R8");
    step(1, 31, 31, 1, 7, 0, "R8");
    step(1, 31, 31, 0, 0, 12, "R8");

    // R10: invalid request and disabled destination record nothing
    step(0, 31, 31, 1, 9, 12, "R10");
    step(1, 9, 31, 0, 9, 12, "R10");
    step(1, 9, 9, 1, 10, 0, "R10");

    // R9: stalled request does not record its destination
    step(1, 31, 31, 1, 11, 4, "R9");
    step(1, 11, 31, 1, 12, 12, "R9");
    step(1, 12, 31, 1, 13, 0, "R9");

    // R11: newer short producer replaces older long one; ready seen with valid low
    step(1, 31, 31, 1, 14, 12, "R11");
    step(0, 14, 31, 0, 0, 0, "R11");
    step(1, 31, 31, 1, 14, 0, "R11");
    step(1, 14, 14, 1, 15, 0, "R11");

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int s0, s1, d, c;
      s0 = ($urandom_range(0, 9) == 0) ? 31 : $urandom_range(0, 7);
      s1 = ($urandom_range(0, 9) == 0) ? 31 : $urandom_range(0, 7);
      d  = ($urandom_range(0, 15) == 0) ? 31 : $urandom_range(0, 7);
      c  = ($urandom_range(0, 3) == 0) ? $urandom_range(13, 18) : $urandom_range(0, 31);
      step($urandom_range(0, 7) != 0, s0, s1, $urandom_range(0, 7) != 0, d, c, "R11");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule